// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes every architectural state change a processor core makes when it takes a trap. The pipeline offers one event per cycle: a hardware exception, a memory-translation exception, an external interrupt, a hardware break or a software break. With the event it presents the current program counter, the pending immediate-prefix and delay-slot flags, the branch target of an unresolved branch, a flag telling whether that branch carried an immediate prefix, the live status register and the live exception status register.

When the sequencer accepts an event, it registers all results in a single cycle and raises a one-cycle redirect strobe. The results are a register-file write of the return address, the new status word, an exception-status update with a branch-target save, a request to clear the pending prefix and delay-slot flags, and the redirected program counter. An interrupt that arrives while the core cannot take it is not accepted. The pipeline keeps it pending and offers it again later.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, `commit`, `rf_we`, `esr_we`, `btr_we` and `flags_clr` are 0, and every data output is 0.
- R2: When `cfg_exc_impl` is 1, a hardware exception (`evt_kind` = 0) writes `pc_in`+4 to register 17, redirects to 0x20, sets the exception-in-progress status bit 9 and raises `flags_clr`.
- R3: When `cfg_exc_impl` is 0, a hardware exception is not accepted: no strobe and no write request of any kind follows it.
- R4: A translation exception (`evt_kind` = 1) writes to register 17 and redirects to 0x20. It sets status bit 9 and raises `flags_clr`. The return address is `pc_in`-8 when `dslot_pending` and `br_prefixed` are both set, and `pc_in`-4 when `dslot_pending` alone is set. With no delay slot it is `pc_in`-4 if `imm_pending` is set and `pc_in` otherwise.
- R5: On either exception kind, `esr_out` is `esr_in` with bit 12 replaced by `dslot_pending`. When `dslot_pending` is set, `btr_we` pulses and `btr_out` is `br_target`.
- R6: On every accepted event, status bits 11 (user mode) and 13 (virtual mode) are copied into bits 12 and 14, and then bits 11 and 13 are cleared. Unnamed status bits pass through unchanged.
- R7: An accepted interrupt (`evt_kind` = 2) writes `pc_in` to register 14, clears the interrupt-enable status bit 1 and redirects to 0x10.
- R8: An interrupt is accepted only if status bit 1 is set, status bits 3 and 9 are clear and `dslot_pending` is 0. Otherwise nothing is committed.
- R9: A hardware break (`evt_kind` = 3) writes `pc_in` to register 16, sets the break-in-progress status bit 3 and redirects to 0x18.
- R10: A software break (`evt_kind` = 4) sets status bit 3, makes no register-file write and redirects to `br_target`.
- R11: Results and strobes appear in the cycle after the event is sampled. Strobes last one cycle for each accepted event. Kinds 5 to 7, and cycles with `evt_valid` low, commit nothing.
- R12: Interrupts and breaks leave `esr_we`, `btr_we` and `flags_clr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is offered this cycle |
| evt_kind | input | 3 | Event kind: 0 hw exception, 1 translation exception, 2 interrupt, 3 hw break, 4 sw break |
| cfg_exc_impl | input | 1 | Hardware exceptions are implemented |
| pc_in | input | 32 | Program counter of the trapped instruction |
| imm_pending | input | 1 | An immediate prefix is pending |
| dslot_pending | input | 1 | The event hit a branch delay slot |
| br_target | input | 32 | Target of the pending branch |
| br_prefixed | input | 1 | The pending branch carried an immediate prefix |
| stat_in | input | 32 | Live status register |
| esr_in | input | 32 | Live exception status register |
| commit | output | 1 | One-cycle redirect and commit strobe |
| next_pc | output | 32 | Redirected program counter |
| rf_we | output | 1 | Register-file write request |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Return address to write |
| stat_out | output | 32 | New status register, valid with `commit` |
| esr_we | output | 1 | Exception status write request |
| esr_out | output | 32 | New exception status value |
| btr_we | output | 1 | Branch target register write request |
| btr_out | output | 32 | Value for the branch target register |
| flags_clr | output | 1 | Clear the pending prefix and delay-slot flags |

## Verification
The bench sweeps every event kind against every combination of the delay-slot, prefix, branch-prefix and configuration inputs, and against 64 status patterns. Expected values are computed arithmetically for each vector. The translation-exception return address is the sharpest corner. A design that ignored `br_prefixed`, or applied the prefix correction on top of the delay-slot correction, would return 4 bytes off and re-execute the wrong instruction. The interrupt gating patterns catch a design that takes an interrupt inside a delay slot or during a handler. The mode-bit patterns catch a design that shifts in the wrong direction or clears the saved copies after writing them. Idle cycles after every event catch strobes that last longer than one cycle.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN       = 32,
  parameter int RF_AW      = 5,
  parameter int INSN_BYTES = 4,
  parameter logic [XLEN-1:0] VEC_IRQ = 32'h10,
  parameter logic [XLEN-1:0] VEC_BRK = 32'h18,
  parameter logic [XLEN-1:0] VEC_EXC = 32'h20,
  parameter int IE_BIT     = 1,
  parameter int BIP_BIT    = 3,
  parameter int EIP_BIT    = 9,
  parameter int UM_BIT     = 11,
  parameter int VM_BIT     = 13,
  parameter int ESR_DS_BIT = 12,
  parameter int RET_EXC    = 17,
  parameter int RET_IRQ    = 14,
  parameter int RET_BRK    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [2:0]       evt_kind,
  input  logic             cfg_exc_impl,
  input  logic [XLEN-1:0]  pc_in,
  input  logic             imm_pending,
  input  logic             dslot_pending,
  input  logic [XLEN-1:0]  br_target,
  input  logic             br_prefixed,
  input  logic [XLEN-1:0]  stat_in,
  input  logic [XLEN-1:0]  esr_in,
  output logic             commit,
  output logic [XLEN-1:0]  next_pc,
  output logic             rf_we,
  output logic [RF_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic [XLEN-1:0]  stat_out,
  output logic             esr_we,
  output logic [XLEN-1:0]  esr_out,
  output logic             btr_we,
  output logic [XLEN-1:0]  btr_out,
  output logic             flags_clr
);

  localparam int UMS_BIT = UM_BIT + 1;
  localparam int VMS_BIT = VM_BIT + 1;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [2:0] K_HWX  = 3'd0;
  localparam logic [2:0] K_MMU  = 3'd1;
  localparam logic [2:0] K_IRQ  = 3'd2;
  localparam logic [2:0] K_HBRK = 3'd3;
  localparam logic [2:0] K_SBRK = 3'd4;

  logic is_hwx, is_mmu, is_irq, is_hbrk, is_sbrk, is_exc, accept;
  logic irq_ok;

  assign irq_ok  = stat_in[IE_BIT] & ~stat_in[EIP_BIT] & ~stat_in[BIP_BIT] & ~dslot_pending;
  assign is_hwx  = evt_valid && evt_kind == K_HWX && cfg_exc_impl;
  assign is_mmu  = evt_valid && evt_kind == K_MMU;
  assign is_irq  = evt_valid && evt_kind == K_IRQ && irq_ok;
  assign is_hbrk = evt_valid && evt_kind == K_HBRK;
  assign is_sbrk = evt_valid && evt_kind == K_SBRK;
  assign is_exc  = is_hwx | is_mmu;
  assign accept  = is_exc | is_irq | is_hbrk | is_sbrk;

  logic [XLEN-1:0] mmu_back;
  assign mmu_back = dslot_pending ? (br_prefixed ? (STEP << 1) : STEP)
                                  : (imm_pending ? STEP : '0);

  logic [XLEN-1:0] stat_saved, stat_nx;
  always_comb begin
    stat_saved = stat_in;
    stat_saved[UMS_BIT] = stat_in[UM_BIT];
    stat_saved[VMS_BIT] = stat_in[VM_BIT];
    stat_saved[UM_BIT]  = 1'b0;
    stat_saved[VM_BIT]  = 1'b0;
    stat_nx = stat_saved;
    if (is_exc)            stat_nx[EIP_BIT] = 1'b1;
    if (is_irq)            stat_nx[IE_BIT]  = 1'b0;
    if (is_hbrk | is_sbrk) stat_nx[BIP_BIT] = 1'b1;
  end

  logic [XLEN-1:0]  ret_nx, pc_nx;
  logic [RF_AW-1:0] idx_nx;
  always_comb begin
    ret_nx = pc_in;
    idx_nx = RF_AW'(RET_EXC);
    pc_nx  = VEC_EXC;
    if (is_hwx)       ret_nx = pc_in + STEP;
    else if (is_mmu)  ret_nx = pc_in - mmu_back;
    if (is_irq) begin
      idx_nx = RF_AW'(RET_IRQ);
      pc_nx  = VEC_IRQ;
    end else if (is_hbrk) begin
      idx_nx = RF_AW'(RET_BRK);
      pc_nx  = VEC_BRK;
    end else if (is_sbrk) begin
      pc_nx  = br_target;
    end
  end

  logic [XLEN-1:0] esr_nx;
  always_comb begin
    esr_nx = esr_in;
    esr_nx[ESR_DS_BIT] = dslot_pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit    <= 1'b0;
      rf_we     <= 1'b0;
      esr_we    <= 1'b0;
      btr_we    <= 1'b0;
      flags_clr <= 1'b0;
      next_pc   <= '0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      stat_out  <= '0;
      esr_out   <= '0;
      btr_out   <= '0;
    end else begin
      commit    <= accept;
      rf_we     <= accept & ~is_sbrk;
      esr_we    <= is_exc;
      btr_we    <= is_exc & dslot_pending;
      flags_clr <= is_exc;
      if (accept) begin
        next_pc  <= pc_nx;
        stat_out <= stat_nx;
      end
      if (accept & ~is_sbrk) begin
        rf_waddr <= idx_nx;
        rf_wdata <= ret_nx;
      end
      if (is_exc) esr_out <= esr_nx;
      if (is_exc & dslot_pending) btr_out <= br_target;
    end
  end

  assert_hwx_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == K_HWX && !cfg_exc_impl) |=> (!commit && !rf_we && !esr_we));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == K_IRQ &&
     (!stat_in[IE_BIT] || stat_in[EIP_BIT] || stat_in[BIP_BIT] || dslot_pending)) |=> !commit);

  assert_live_modes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!stat_out[VM_BIT] && !stat_out[UM_BIT]));

  assert_btr_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    btr_we |-> (esr_we && esr_out[ESR_DS_BIT]));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> (!commit && !rf_we && !esr_we && !btr_we && !flags_clr));

  assert_exc_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_clr) |-> (commit && next_pc == VEC_EXC && stat_out[EIP_BIT]));

endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_kind = '0;
  logic        cfg_exc_impl = 1'b0;
  logic [31:0] pc_in = '0;
  logic        imm_pending = 1'b0;
  logic        dslot_pending = 1'b0;
  logic [31:0] br_target = '0;
  logic        br_prefixed = 1'b0;
  logic [31:0] stat_in = '0;
  logic [31:0] esr_in = '0;
  logic        commit, rf_we, esr_we, btr_we, flags_clr;
  logic [31:0] next_pc, rf_wdata, stat_out, esr_out, btr_out;
  logic [4:0]  rf_waddr;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .cfg_exc_impl(cfg_exc_impl), .pc_in(pc_in), .imm_pending(imm_pending),
    .dslot_pending(dslot_pending), .br_target(br_target), .br_prefixed(br_prefixed),
    .stat_in(stat_in), .esr_in(esr_in), .commit(commit), .next_pc(next_pc),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .stat_out(stat_out),
    .esr_we(esr_we), .esr_out(esr_out), .btr_we(btr_we), .btr_out(btr_out),
    .flags_clr(flags_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  logic        acc, ewe;
  logic [31:0] epc, edata, estat, eesr;
  logic [4:0]  eidx;
  string       ktag;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 commit", {31'b0, commit}, 32'h0);
    chk("R1 strobes", {27'b0, rf_we, esr_we, btr_we, flags_clr, 1'b0}, 32'h0);
    chk("R1 next_pc", next_pc, 32'h0);
    chk("R1 stat_out", stat_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {27'b0, commit, rf_we, esr_we, btr_we, flags_clr}, 32'h0);

    for (int v = 0; v < 8192; v++) begin
      automatic logic [2:0] k  = v[2:0];
      automatic logic       ds = v[3];
      automatic logic       im = v[4];
      automatic logic       pf = v[5];
      automatic logic       cf = v[6];
      automatic logic [5:0] s  = v[12:7];
      automatic logic [31:0] st = 32'h8000_0020;
      st[1] = s[0]; st[3] = s[1]; st[9] = s[2]; st[11] = s[3]; st[13] = s[4];
      st[12] = s[5]; st[14] = s[5];

      evt_valid = 1'b1; evt_kind = k; cfg_exc_impl = cf;
      pc_in = 32'h1000_0100 + (v << 2);
      imm_pending = im; dslot_pending = ds; br_prefixed = pf;
      br_target = 32'h4000_0000 ^ (v << 3);
      stat_in = st;
      esr_in = 32'h5A5A_A5A5 ^ v;

      case (k)
        3'd0: begin acc = cf; ktag = "R2"; end
        3'd1: begin acc = 1'b1; ktag = "R4"; end
        3'd2: begin acc = st[1] && !st[3] && !st[9] && !ds; ktag = "R7"; end
        3'd3: begin acc = 1'b1; ktag = "R9"; end
        3'd4: begin acc = 1'b1; ktag = "R10"; end
        default: begin acc = 1'b0; ktag = "R11"; end
      endcase
      ewe = acc && k != 3'd4;
      case (k)
        3'd0, 3'd1: epc = 32'h20;
        3'd2: epc = 32'h10;
        3'd3: epc = 32'h18;
        default: epc = br_target;
      endcase
      case (k)
        3'd0: begin eidx = 5'd17; edata = pc_in + 4; end
        3'd1: begin
          eidx = 5'd17;
          edata = ds ? (pc_in - 4 - (pf ? 4 : 0)) : (pc_in - (im ? 4 : 0));
        end
        3'd2: begin eidx = 5'd14; edata = pc_in; end
        default: begin eidx = 5'd16; edata = pc_in; end
      endcase
      estat = st & ~32'h0000_7800;
      estat[12] = st[11];
      estat[14] = st[13];
      if (k < 3'd2) estat[9] = 1'b1;
      if (k == 3'd2) estat[1] = 1'b0;
      if (k == 3'd3 || k == 3'd4) estat[3] = 1'b1;
      eesr = esr_in;
      eesr[12] = ds;

      @(posedge clk);
      @(negedge clk);
      evt_valid = 1'b0;

      if (!acc) begin
        if (k == 3'd0)      chk("R3 ignored", {28'b0, commit, rf_we, esr_we, btr_we}, 32'h0);
        else if (k == 3'd2) chk("R8 deferred", {28'b0, commit, rf_we, esr_we, btr_we}, 32'h0);
        else                chk("R11 unused kind", {28'b0, commit, rf_we, esr_we, btr_we}, 32'h0);
      end else begin
        chk({"R11 commit ", ktag}, {31'b0, commit}, 32'h1);
        chk({ktag, " next_pc"}, next_pc, epc);
        chk({ktag, " rf_we"}, {31'b0, rf_we}, {31'b0, ewe});
        if (ewe) begin
          chk({ktag, " rf_waddr"}, {27'b0, rf_waddr}, {27'b0, eidx});
          chk({ktag, " rf_wdata"}, rf_wdata, edata);
        end
        chk({"R6 stat_out ", ktag}, stat_out, estat);
        if (k < 3'd2) begin
          chk("R5 esr_we", {31'b0, esr_we}, 32'h1);
          chk("R5 esr_out", esr_out, eesr);
          chk("R5 btr_we", {31'b0, btr_we}, {31'b0, ds});
          if (ds) chk("R5 btr_out", btr_out, br_target);
          chk({ktag, " flags_clr"}, {31'b0, flags_clr}, 32'h1);
        end else begin
          chk("R12 no esr/btr/flags", {29'b0, esr_we, btr_we, flags_clr}, 32'h0);
        end
      end

      @(negedge clk);
      chk("R11 one-cycle strobe", {27'b0, commit, rf_we, esr_we, btr_we, flags_clr}, 32'h0);
    end

    finish_run();
  end
endmodule